// File: doc/BRIEF.md
# Input Range Gain Programmer

This block turns a per-channel input-range choice into gain settings for the two programmable amplifiers that sit in series in each analog channel. Each amplifier takes a gain of 1, 2, 5 or 10, and nine bipolar ranges are defined as pairs of those gains. The block writes the settings over SPI to serial-to-parallel expanders. There is one expander for each pair of channels, and each expander drives twelve amplifier control lines: three per amplifier, made of two gain-select bits and a write-enable strobe.

Software presents four 4-bit range codes and pulses `start` while no acquisition is running. The block latches the valid codes into its settings register. It then sends six SPI frames: three to the expander for channels 0–1, followed by three to the expander for channels 2–3. The three frames for one expander place the gain bits with the strobe low, raise the strobe, and then drop it again. A one-cycle `done` pulse follows the last frame.

The control pins are plain level or pulse signals. There is no streaming data path, so none of the pins uses valid/ready back-pressure.

Top module: `range_gain_prog`

## Requirements
- R1: After reset `cs_n` is 1, `sclk` is 0 and `done`, `start_rej` and `range_err` are 0. Every channel's stored setting is the ±10 V range, which is both gains equal to 1 (select code 00).
- R2: Gain-select codes are 00 for gain 1, 01 for gain 2, 10 for gain 5 and 11 for gain 10. Range codes 0 to 8 give the (first, second) gains (10,10), (10,5), (5,5), (10,2), (5,2), (5,1), (2,2), (2,1) and (1,1).
- R3: Each frame is 24 bits, sent MSB first. Bits 23:16 are 0x40 OR (expander index shifted left by 1). Bits 15:12 are 0. Bits 2:0 are {strobe, first-amplifier select} of the lower channel of the pair, and bits 5:3 are {strobe, second-amplifier select} of that channel. Bits 8:6 and 11:9 hold the same two fields for the upper channel.
- R4: An accepted start produces exactly six frames in a fixed order. Expander 0 comes before expander 1, and each expander gets the strobe values 0, then 1, then 0.
- R5: SPI mode 0 applies. `sclk` is low whenever `cs_n` is high. `mosi` holds steady while `sclk` is high. Each frame has exactly 24 rising `sclk` edges while `cs_n` is low.
- R6: Between two frames `cs_n` stays high for at least two SCLK periods (4·SCLK_HALF clock cycles).
- R7: `done` pulses for exactly one cycle per accepted start, after the sixth frame has ended, with `cs_n` high.
- R8: A `start` while `acq_busy` is 1 sends no frames and changes no setting. `start_rej` pulses in the following cycle.
- R9: A channel whose code is 9 to 15 keeps its previous setting while the valid channels update. `range_err` pulses in the cycle after the start, and the six frames are still sent.
- R10: A `start` that arrives while a sequence is running is ignored without raising any flag, and the running sequence completes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| range_sel | input | 16 | Four 4-bit range codes, channel n in bits 4n+3:4n |
| start | input | 1 | Single-cycle request to program the gains |
| acq_busy | input | 1 | High while an acquisition is running |
| sclk | output | 1 | SPI clock, idles low |
| mosi | output | 1 | SPI serial data |
| cs_n | output | 1 | SPI chip select, active low |
| done | output | 1 | One-cycle pulse when all six frames have been sent |
| start_rej | output | 1 | One-cycle pulse when a start is refused during acquisition |
| range_err | output | 1 | One-cycle pulse when a start carried an invalid code |

## Verification
The bench builds the block with SCLK_HALF = 1. In that setting the serializer toggles `sclk` on every clock, the inter-frame gap is at its smallest legal length, and the shortest path from `fin` to the next frame start is exercised. A full six-frame sequence takes only a few hundred cycles, so the bench can cover all nine ranges, invalid codes on reset-state and on updated settings, a refused start during acquisition, and a start issued in the middle of a sequence. The channel count stays at four, which exercises both expander indices in the frame header.

// File: rtl/gp_pkg.sv
package gp_pkg;
  typedef logic [1:0] gsel_t;

  typedef struct packed {
    gsel_t a1;
    gsel_t a2;
  } chgain_t;

  localparam int unsigned NUM_RANGES = 9;
  localparam chgain_t GAIN_AT_RESET = '{a1: 2'b00, a2: 2'b00};
endpackage

// File: rtl/gp_range_lut.sv
module gp_range_lut
  import gp_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int CODE_W = 4
) (
  input  logic [NCH-1:0][CODE_W-1:0] code,
  output chgain_t                    gain [NCH],
  output logic    [NCH-1:0]          valid
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    always_comb begin
      valid[c] = 1'b1;
      gain[c]  = GAIN_AT_RESET;
      case (int'(code[c]))
        0: gain[c] = '{a1: 2'b11, a2: 2'b11};
        1: gain[c] = '{a1: 2'b11, a2: 2'b10};
        2: gain[c] = '{a1: 2'b10, a2: 2'b10};
        3: gain[c] = '{a1: 2'b11, a2: 2'b01};
        4: gain[c] = '{a1: 2'b10, a2: 2'b01};
        5: gain[c] = '{a1: 2'b10, a2: 2'b00};
        6: gain[c] = '{a1: 2'b01, a2: 2'b01};
        7: gain[c] = '{a1: 2'b01, a2: 2'b00};
        8: gain[c] = '{a1: 2'b00, a2: 2'b00};
        default: valid[c] = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/gp_frame_pack.sv
module gp_frame_pack
  import gp_pkg::*;
#(
  parameter int NCH     = 4,
  parameter int FRAME_W = 24,
  parameter int EW      = 1
) (
  input  chgain_t              gains [NCH],
  input  logic [EW-1:0]        exp_sel,
  input  logic                 strobe,
  output logic [FRAME_W-1:0]   word
);
  localparam int DATA_W = 16;
  localparam int HDR_W  = FRAME_W - DATA_W;

  logic [HDR_W-1:0]  hdr;
  logic [DATA_W-1:0] data;
  chgain_t           lo, hi;

  always_comb begin
    lo   = gains[2 * int'(exp_sel)];
    hi   = gains[2 * int'(exp_sel) + 1];
    hdr  = HDR_W'(8'h40) | (HDR_W'(exp_sel) << 1);
    data = '0;
    data[2:0]  = {strobe, lo.a1};
    data[5:3]  = {strobe, lo.a2};
    data[8:6]  = {strobe, hi.a1};
    data[11:9] = {strobe, hi.a2};
    word = {hdr, data};
  end
endmodule

// File: rtl/gp_spi_tx.sv
module gp_spi_tx #(
  parameter int FRAME_W   = 24,
  parameter int SCLK_HALF = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               go,
  input  logic [FRAME_W-1:0] word,
  output logic               sclk,
  output logic               mosi,
  output logic               cs_n,
  output logic               fin
);
  localparam int GAP_CYC = 4 * SCLK_HALF;
  localparam int CW      = $clog2(GAP_CYC + 1);
  localparam int BW      = $clog2(FRAME_W);

  typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_TAIL, ST_GAP} st_t;

  st_t                st;
  logic [FRAME_W-1:0] sh;
  logic [CW-1:0]      cnt;
  logic [BW-1:0]      bits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      sh   <= '0;
      cnt  <= '0;
      bits <= '0;
      sclk <= 1'b0;
      cs_n <= 1'b1;
      fin  <= 1'b0;
    end else begin
      fin <= 1'b0;
      case (st)
        ST_IDLE: if (go) begin
          sh   <= word;
          cs_n <= 1'b0;
          cnt  <= '0;
          bits <= '0;
          st   <= ST_SHIFT;
        end
        ST_SHIFT: begin
          if (cnt == CW'(SCLK_HALF - 1)) begin
            cnt <= '0;
            if (!sclk) begin
              sclk <= 1'b1;
            end else begin
              sclk <= 1'b0;
              if (bits == BW'(FRAME_W - 1)) begin
                st <= ST_TAIL;
              end else begin
                bits <= bits + 1'b1;
                sh   <= {sh[FRAME_W-2:0], 1'b0};
              end
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_TAIL: begin
          if (cnt == CW'(SCLK_HALF - 1)) begin
            cnt  <= '0;
            cs_n <= 1'b1;
            st   <= ST_GAP;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          if (cnt == CW'(GAP_CYC - 1)) begin
            cnt <= '0;
            fin <= 1'b1;
            st  <= ST_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      endcase
    end
  end

  assign mosi = !cs_n && sh[FRAME_W-1];
endmodule

// File: rtl/range_gain_prog.sv
module range_gain_prog
  import gp_pkg::*;
#(
  parameter int NCH       = 4,
  parameter int CODE_W    = 4,
  parameter int FRAME_W   = 24,
  parameter int SCLK_HALF = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NCH*CODE_W-1:0]   range_sel,
  input  logic                    start,
  input  logic                    acq_busy,
  output logic                    sclk,
  output logic                    mosi,
  output logic                    cs_n,
  output logic                    done,
  output logic                    start_rej,
  output logic                    range_err
);
  localparam int NEXP        = NCH / 2;
  localparam int EW          = (NEXP > 1) ? $clog2(NEXP) : 1;
  localparam int STEPS       = 3;

  logic [NCH-1:0][CODE_W-1:0] codes;
  chgain_t                    lut_gain [NCH];
  logic    [NCH-1:0]          lut_ok;
  chgain_t                    cur [NCH];
  logic                       running;
  logic [EW-1:0]              exp_idx;
  logic [1:0]                 step;
  logic                       go, fin;
  logic [FRAME_W-1:0]         word;

  assign codes = range_sel;

  gp_range_lut #(.NCH(NCH), .CODE_W(CODE_W)) u_lut (
    .code(codes), .gain(lut_gain), .valid(lut_ok)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_set
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        cur[c] <= GAIN_AT_RESET;
      else if (start && !running && !acq_busy && lut_ok[c])
        cur[c] <= lut_gain[c];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running   <= 1'b0;
      exp_idx   <= '0;
      step      <= '0;
      go        <= 1'b0;
      done      <= 1'b0;
      start_rej <= 1'b0;
      range_err <= 1'b0;
    end else begin
      go        <= 1'b0;
      done      <= 1'b0;
      start_rej <= 1'b0;
      range_err <= 1'b0;
      if (!running) begin
        if (start && acq_busy) begin
          start_rej <= 1'b1;
        end else if (start) begin
          range_err <= !(&lut_ok);
          running   <= 1'b1;
          exp_idx   <= '0;
          step      <= '0;
          go        <= 1'b1;
        end
      end else if (fin) begin
        if (step == 2'(STEPS - 1)) begin
          step <= '0;
          if (exp_idx == EW'(NEXP - 1)) begin
            running <= 1'b0;
            done    <= 1'b1;
          end else begin
            exp_idx <= exp_idx + 1'b1;
            go      <= 1'b1;
          end
        end else begin
          step <= step + 1'b1;
          go   <= 1'b1;
        end
      end
    end
  end

  gp_frame_pack #(.NCH(NCH), .FRAME_W(FRAME_W), .EW(EW)) u_pack (
    .gains(cur), .exp_sel(exp_idx), .strobe(step == 2'd1), .word(word)
  );

  gp_spi_tx #(.FRAME_W(FRAME_W), .SCLK_HALF(SCLK_HALF)) u_tx (
    .clk(clk), .rst_n(rst_n), .go(go), .word(word),
    .sclk(sclk), .mosi(mosi), .cs_n(cs_n), .fin(fin)
  );
endmodule

// File: rtl/gp_checker.sv
module gp_checker #(
  parameter int SCLK_HALF = 2
) (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic acq_busy,
  input logic sclk,
  input logic mosi,
  input logic cs_n,
  input logic done,
  input logic start_rej,
  input logic range_err
);
  logic [15:0] hi_cnt;
  logic        seen_frame;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt     <= '0;
      seen_frame <= 1'b0;
    end else begin
      if (!cs_n) seen_frame <= 1'b1;
      if (cs_n) hi_cnt <= (hi_cnt == 16'hFFFF) ? hi_cnt : hi_cnt + 1'b1;
      else      hi_cnt <= '0;
    end
  end

  a_r5_sclk_low_idle: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);
  a_r5_mosi_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && sclk && $past(sclk)) |-> $stable(mosi));
  a_r6_gap: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cs_n) && seen_frame) |-> (hi_cnt >= 16'(4 * SCLK_HALF)));
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r7_done_cs_high: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cs_n);
  a_r8_reject_cause: assert property (@(posedge clk) disable iff (!rst_n)
    start_rej |-> ($past(start) && $past(acq_busy)));
  a_r8_reject_no_frame: assert property (@(posedge clk) disable iff (!rst_n)
    start_rej |-> cs_n);
  a_r9_err_not_rej: assert property (@(posedge clk) disable iff (!rst_n)
    range_err |-> !start_rej);
endmodule

bind range_gain_prog gp_checker #(.SCLK_HALF(SCLK_HALF)) u_gp_checker (
  .clk(clk), .rst_n(rst_n), .start(start), .acq_busy(acq_busy),
  .sclk(sclk), .mosi(mosi), .cs_n(cs_n), .done(done),
  .start_rej(start_rej), .range_err(range_err)
);

// File: tb/test_range_gain_prog.sv
module test_range_gain_prog;
  localparam int HALF = 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] range_sel = '0;
  logic        start = 1'b0;
  logic        acq_busy = 1'b0;
  logic        sclk, mosi, cs_n, done, start_rej, range_err;

  always #2.5 clk = ~clk;

  range_gain_prog #(.SCLK_HALF(HALF)) i_range_gain_prog (
    .clk(clk), .rst_n(rst_n), .range_sel(range_sel), .start(start),
    .acq_busy(acq_busy), .sclk(sclk), .mosi(mosi), .cs_n(cs_n),
    .done(done), .start_rej(start_rej), .range_err(range_err)
  );

  int n_chk = 0;
  int n_err = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // behavioural reference: stored gains as plain integers
  int mg1 [4] = '{1, 1, 1, 1};
  int mg2 [4] = '{1, 1, 1, 1};

  function automatic int first_gain(input int c);
    case (c)
      0, 1, 3: return 10;
      2, 4, 5: return 5;
      6, 7:    return 2;
      default: return 1;
    endcase
  endfunction

  function automatic int second_gain(input int c);
    case (c)
      0:       return 10;
      1, 2:    return 5;
      3, 4, 6: return 2;
      default: return 1;
    endcase
  endfunction

  function automatic int enc(input int g);
    case (g)
      1: return 0;
      2: return 1;
      5: return 2;
      default: return 3;
    endcase
  endfunction

  function automatic int exp_frame(input int e, input int we);
    int lo = 2 * e;
    int hi = 2 * e + 1;
    int d;
    d = (enc(mg1[lo]) + we * 4)
      | ((enc(mg2[lo]) + we * 4) << 3)
      | ((enc(mg1[hi]) + we * 4) << 6)
      | ((enc(mg2[hi]) + we * 4) << 9);
    return ((8'h40 | (e << 1)) << 16) | d;
  endfunction

  // per-clock port monitor
  int  frames [$];
  int  nbits  [$];
  int  cur_word = 0, cur_bits = 0;
  bit  sclk_d = 1'b0, cs_d = 1'b1, mosi_d = 1'b0;
  int  hi_run = 0;
  int  done_cnt = 0, frames_at_done = -1;
  int  viol_idle = 0, viol_hold = 0, viol_gap = 0, viol_done = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (cs_n && sclk) viol_idle++;
      if (!cs_n && sclk && sclk_d && mosi != mosi_d) viol_hold++;
      if (!cs_n && cs_d && frames.size() > 0 && hi_run < 4 * HALF) viol_gap++;
      if (!cs_n && sclk && !sclk_d) begin
        cur_word = (cur_word << 1) | int'(mosi);
        cur_bits++;
      end
      if (cs_n && !cs_d) begin
        frames.push_back(cur_word & 24'hFFFFFF);
        nbits.push_back(cur_bits);
        cur_word = 0;
        cur_bits = 0;
      end
      if (done) begin
        done_cnt++;
        frames_at_done = frames.size();
        if (!cs_n) viol_done++;
      end
      hi_run = cs_n ? hi_run + 1 : 0;
      sclk_d = sclk;
      cs_d   = cs_n;
      mosi_d = mosi;
    end
  end

  task automatic set_codes(input int c0, input int c1, input int c2, input int c3);
    range_sel = {4'(c3), 4'(c2), 4'(c1), 4'(c0)};
  endtask

  task automatic pulse_start();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic clear_mon();
    frames.delete();
    nbits.delete();
    done_cnt = 0;
    frames_at_done = -1;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 3000 && done_cnt == 0; i++) @(negedge clk);
    repeat (20) @(negedge clk);
  endtask

  task automatic check_frames(input string tag);
    check(frames.size() == 6, "R4", {tag, " frame count"}, frames.size(), 6);
    check(done_cnt == 1, "R7", {tag, " done pulses"}, done_cnt, 1);
    check(frames_at_done == 6, "R7", {tag, " frames before done"}, frames_at_done, 6);
    for (int f = 0; f < 6 && f < frames.size(); f++) begin
      int e  = f / 3;
      int we = ((f % 3) == 1) ? 1 : 0;
      check(nbits[f] == 24, "R5", {tag, " bits per frame"}, nbits[f], 24);
      check(frames[f] == exp_frame(e, we), "R3", {tag, " frame word"},
            frames[f], exp_frame(e, we));
    end
  endtask

  // runs one accepted start; bad_mask marks channels expected invalid
  task automatic run_seq(input int c0, input int c1, input int c2, input int c3,
                         input string tag);
    int cs [4] = '{c0, c1, c2, c3};
    bit any_bad = 1'b0;
    clear_mon();
    set_codes(c0, c1, c2, c3);
    pulse_start();
    for (int c = 0; c < 4; c++) begin
      if (cs[c] < 9) begin
        mg1[c] = first_gain(cs[c]);
        mg2[c] = second_gain(cs[c]);
      end else begin
        any_bad = 1'b1;
      end
    end
    check(range_err == any_bad, "R9", {tag, " range_err"}, range_err, any_bad);
    check(start_rej == 1'b0, "R8", {tag, " start_rej"}, start_rej, 0);
    wait_done();
    check_frames(tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state at the ports
    check(cs_n == 1'b1, "R1", "cs_n in reset", cs_n, 1);
    check(sclk == 1'b0, "R1", "sclk in reset", sclk, 0);
    check(done == 1'b0 && start_rej == 1'b0 && range_err == 1'b0, "R1",
          "flags in reset", {done, start_rej, range_err}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 + R9: all codes invalid, frames must show reset gains
    run_seq(15, 9, 12, 10, "reset gains");
    // R2: range table, every valid code
    run_seq(0, 1, 2, 3, "codes0-3");
    run_seq(4, 5, 6, 7, "codes4-7");
    run_seq(8, 0, 4, 2, "codes8/0/4/2");
    // R9: mix of valid and invalid channels
    run_seq(9, 3, 13, 6, "mixed invalid");

    // R8: start during acquisition is refused and leaves settings alone
    clear_mon();
    acq_busy = 1'b1;
    set_codes(0, 0, 0, 0);
    pulse_start();
    check(start_rej == 1'b1, "R8", "start_rej pulse", start_rej, 1);
    check(range_err == 1'b0, "R8", "no range_err on reject", range_err, 0);
    @(negedge clk);
    check(start_rej == 1'b0, "R8", "start_rej single cycle", start_rej, 0);
    repeat (300) @(negedge clk);
    check(frames.size() == 0, "R8", "no frames on reject", frames.size(), 0);
    check(done_cnt == 0, "R8", "no done on reject", done_cnt, 0);
    acq_busy = 1'b0;
    run_seq(14, 11, 15, 9, "after reject");

    // R10: start mid-sequence is ignored
    clear_mon();
    set_codes(7, 6, 5, 4);
    pulse_start();
    for (int c = 0; c < 4; c++) begin
      mg1[c] = first_gain(7 - c);
      mg2[c] = second_gain(7 - c);
    end
    repeat (60) @(negedge clk);
    set_codes(0, 0, 0, 0);
    pulse_start();
    check(start_rej == 1'b0 && range_err == 1'b0, "R10", "no flag mid-sequence",
          {start_rej, range_err}, 0);
    wait_done();
    check_frames("mid-start");
    repeat (300) @(negedge clk);
    check(frames.size() == 6, "R10", "no extra frames", frames.size(), 6);

    // per-clock rule tallies
    check(viol_idle == 0, "R5", "sclk high while cs_n high", viol_idle, 0);
    check(viol_hold == 0, "R5", "mosi moved while sclk high", viol_hold, 0);
    check(viol_gap == 0, "R6", "short gap between frames", viol_gap, 0);
    check(viol_done == 0, "R7", "done while cs_n low", viol_done, 0);

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule